// File: doc/BRIEF.md
# Receiver PHY Control Bridge with Lane Reconfiguration Steering

This block is the host-facing control slave of a serial receiver PHY. A word-addressed host bus reaches two kinds of target through it. The lower part of the host address space is a pass-through window. Accesses there are forwarded to the byte-addressed reconfiguration port of one of three receiver lanes, and the forwarded address is the host offset divided by four. The upper part holds a few local registers. Some of these are status words sampled from the PHY: the clock measurement, its valid flag, the power-up calibration flag, the calibration-busy flag and the live lane waitrequest. The others are control bits: the lane select, the reconfiguration ownership bit and the receiver reset.

The lane reconfiguration ports are shared with an internal alternate master. The ownership bit decides which master drives them. When the host owns them, the alternate master sees a permanent waitrequest. The host bus follows the usual memory-mapped waitrequest rules. Address, strobes and write data must be held while `host_waitrequest` is high. An access completes in the first cycle with `host_waitrequest` low, and read data is valid in that same cycle. A window access is stalled for as long as the selected lane holds its waitrequest. A local access never stalls.

Top module: `rxphy_csr_bridge`

## Requirements
- R1: After reset, `lane_sel`, `rcfg_en` and `rx_reset` are 0, and the lane-select, ownership and receiver-reset registers read 0.
- R2: A window access (host offset below 0x1000) puts host offset bits [11:2] on the selected lane's `rcfg_addr`, so lane byte register N is reached at host offset 4*N.
- R3: While `rcfg_en` is 1, only the lane named by `lane_sel` receives the host read or write strobe and write data, and no other lane sees a strobe.
- R4: During a window access that the host owns, `host_waitrequest` equals the selected lane's `rcfg_waitreq`, and `host_rdata` equals that lane's `rcfg_rdata`.
- R5: While `rcfg_en` is 0, each lane's address, strobes and write data come from the matching alternate-master inputs, and `alt_waitreq` follows the lane waitrequest. While `rcfg_en` is 1, every `alt_waitreq` bit is 1.
- R6: A window access while `rcfg_en` is 0 or `lane_sel` is 3 completes at once with `host_waitrequest` low. A read returns 0, and no lane receives a host strobe.
- R7: The lane-select register at 0x1040 is read/write in bits [1:0], drives `lane_sel`, and reads 0 in bits [31:2].
- R8: Bit 0 at 0x1050 is read/write and drives `rcfg_en`. Bit 0 at 0x1060 is read/write and drives `rx_reset`. The next clock after the write takes effect.
- R9: Reads of 0x1000 (32-bit measurement), 0x1010 bit 0 (measurement valid), 0x1020 bit 0 (power-up calibration done) and 0x1030 bit 0 (calibration busy) return the input value captured at the previous clock edge. All other bits read 0.
- R10: 0x1070 bit 0 reads the current waitrequest of the lane named by `lane_sel`, or 0 when `lane_sel` is 3.
- R11: 0x1080 reads 0. Writes to read-only or unmapped local offsets change nothing. Offsets are decoded on the full address, so reads of 0x1004 or any other unmapped local offset return 0.
- R12: Every local register access has `host_waitrequest` low in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 13 | Host word offset |
| host_read | input | 1 | Host read strobe |
| host_write | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid when waitrequest is low |
| host_waitrequest | output | 1 | Host stall |
| alt_addr | input | 30 | Alternate master byte address, 10 bits per lane |
| alt_read | input | 3 | Alternate master read strobe per lane |
| alt_write | input | 3 | Alternate master write strobe per lane |
| alt_wdata | input | 96 | Alternate master write data, 32 bits per lane |
| alt_rdata | output | 96 | Lane read data returned to the alternate master |
| alt_waitreq | output | 3 | Alternate master stall per lane |
| rcfg_addr | output | 30 | Lane reconfiguration byte address |
| rcfg_read | output | 3 | Lane reconfiguration read strobe |
| rcfg_write | output | 3 | Lane reconfiguration write strobe |
| rcfg_wdata | output | 96 | Lane reconfiguration write data |
| rcfg_rdata | input | 96 | Lane reconfiguration read data |
| rcfg_waitreq | input | 3 | Lane reconfiguration waitrequest |
| meas_count | input | 32 | Receive clock measurement |
| meas_valid | input | 1 | Measurement valid flag |
| pwrup_cal_done | input | 1 | Power-up calibration complete |
| rx_cal_busy | input | 1 | Receiver calibration in progress |
| lane_sel | output | 2 | Lane select register value |
| rcfg_en | output | 1 | Host owns the reconfiguration ports |
| rx_reset | output | 1 | Receiver reset (analog and digital) |

## Verification
On every cycle the assertions check these behaviours: local accesses never stall, at most one lane gets a host strobe under host ownership, the host stall mirrors the selected lane, blocked window accesses return zero without stalling, the alternate master is held off while the host owns the ports, status words match the previous-cycle inputs, and control writes land one edge later. Some behaviour only the bench scenarios can show. These include the exact address translation into each lane, the per-lane pass-through of the alternate master, reserved-bit masking, and the fact that writes to read-only and unmapped offsets leave every register untouched. Many random mixes of lane select, ownership, lane waitrequests and read data cover these cases.

// File: rtl/rxcsr_pkg.sv
package rxcsr_pkg;
  // Local register offsets, matched on the full host address
  localparam int unsigned OFF_WIN_END = 32'h1000;
  localparam int unsigned OFF_MEAS    = 32'h1000;
  localparam int unsigned OFF_MVAL    = 32'h1010;
  localparam int unsigned OFF_CALDONE = 32'h1020;
  localparam int unsigned OFF_CALBUSY = 32'h1030;
  localparam int unsigned OFF_LANE    = 32'h1040;
  localparam int unsigned OFF_OWN     = 32'h1050;
  localparam int unsigned OFF_RST     = 32'h1060;
  localparam int unsigned OFF_WAIT    = 32'h1070;
  localparam int unsigned OFF_CFG     = 32'h1080;

  // Clock-source selection reported by the config word (0 = default source)
  localparam logic CFG_CLKSRC = 1'b0;

  typedef enum logic [3:0] {
    RG_NONE, RG_WIN, RG_MEAS, RG_MVAL, RG_CALDONE, RG_CALBUSY,
    RG_LANE, RG_OWN, RG_RST, RG_WAIT, RG_CFG
  } region_e;
endpackage

// File: rtl/rxcsr_decode.sv
module rxcsr_decode
  import rxcsr_pkg::*;
#(
  parameter int HOST_AW = 13
) (
  input  logic [HOST_AW-1:0] addr,
  output region_e            region
);
  always_comb begin
    if (addr < HOST_AW'(OFF_WIN_END)) begin
      region = RG_WIN;
    end else begin
      case (addr)
        HOST_AW'(OFF_MEAS):    region = RG_MEAS;
        HOST_AW'(OFF_MVAL):    region = RG_MVAL;
        HOST_AW'(OFF_CALDONE): region = RG_CALDONE;
        HOST_AW'(OFF_CALBUSY): region = RG_CALBUSY;
        HOST_AW'(OFF_LANE):    region = RG_LANE;
        HOST_AW'(OFF_OWN):     region = RG_OWN;
        HOST_AW'(OFF_RST):     region = RG_RST;
        HOST_AW'(OFF_WAIT):    region = RG_WAIT;
        HOST_AW'(OFF_CFG):     region = RG_CFG;
        default:               region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rxcsr_regs.sv
module rxcsr_regs
  import rxcsr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  region_e           region,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     meas_count,
  input  logic              meas_valid,
  input  logic              pwrup_cal_done,
  input  logic              rx_cal_busy,
  input  logic              sel_wait,
  output logic [LSEL_W-1:0] lane_q,
  output logic              own_q,
  output logic              rst_q,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] meas_q;
  logic          mval_q, done_q, busy_q;

  // Status sampling stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_q <= '0;
      mval_q <= 1'b0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      meas_q <= meas_count;
      mval_q <= meas_valid;
      done_q <= pwrup_cal_done;
      busy_q <= rx_cal_busy;
    end
  end

  // Control bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      own_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else if (wr_en) begin
      case (region)
        RG_LANE: lane_q <= wdata[LSEL_W-1:0];
        RG_OWN:  own_q  <= wdata[0];
        RG_RST:  rst_q  <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (region)
      RG_MEAS:    rdata = meas_q;
      RG_MVAL:    rdata = DW'(mval_q);
      RG_CALDONE: rdata = DW'(done_q);
      RG_CALBUSY: rdata = DW'(busy_q);
      RG_LANE:    rdata = DW'(lane_q);
      RG_OWN:     rdata = DW'(own_q);
      RG_RST:     rdata = DW'(rst_q);
      RG_WAIT:    rdata = DW'(sel_wait);
      RG_CFG:     rdata = DW'(CFG_CLKSRC);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxcsr_lane_mux.sv
module rxcsr_lane_mux #(
  parameter int LANES  = 3,
  parameter int AW     = 10,
  parameter int DW     = 32,
  parameter int LSEL_W = 2
) (
  input  logic                own,
  input  logic                host_live,
  input  logic [LSEL_W-1:0]   lane_sel,
  input  logic [AW-1:0]       host_baddr,
  input  logic                host_read,
  input  logic                host_write,
  input  logic [DW-1:0]       host_wdata,
  input  logic [LANES*AW-1:0] alt_addr,
  input  logic [LANES-1:0]    alt_read,
  input  logic [LANES-1:0]    alt_write,
  input  logic [LANES*DW-1:0] alt_wdata,
  output logic [LANES*DW-1:0] alt_rdata,
  output logic [LANES-1:0]    alt_waitreq,
  output logic [LANES*AW-1:0] rcfg_addr,
  output logic [LANES-1:0]    rcfg_read,
  output logic [LANES-1:0]    rcfg_write,
  output logic [LANES*DW-1:0] rcfg_wdata,
  input  logic [LANES*DW-1:0] rcfg_rdata,
  input  logic [LANES-1:0]    rcfg_waitreq,
  output logic                sel_wait,
  output logic [DW-1:0]       sel_rdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = host_live && (lane_sel == LSEL_W'(i));
    assign rcfg_addr[i*AW +: AW]  = own ? host_baddr : alt_addr[i*AW +: AW];
    assign rcfg_wdata[i*DW +: DW] = own ? host_wdata : alt_wdata[i*DW +: DW];
    assign rcfg_read[i]   = own ? (hit && host_read)  : alt_read[i];
    assign rcfg_write[i]  = own ? (hit && host_write) : alt_write[i];
    assign alt_rdata[i*DW +: DW] = rcfg_rdata[i*DW +: DW];
    assign alt_waitreq[i] = own ? 1'b1 : rcfg_waitreq[i];
  end

  always_comb begin
    sel_wait  = 1'b0;
    sel_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_sel == LSEL_W'(i)) begin
        sel_wait  = rcfg_waitreq[i];
        sel_rdata = rcfg_rdata[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/rxphy_csr_bridge.sv
module rxphy_csr_bridge
  import rxcsr_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int DW      = 32,
  parameter int HOST_AW = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [HOST_AW-1:0]         host_addr,
  input  logic                       host_read,
  input  logic                       host_write,
  input  logic [DW-1:0]              host_wdata,
  output logic [DW-1:0]              host_rdata,
  output logic                       host_waitrequest,
  input  logic [LANES*(HOST_AW-3)-1:0] alt_addr,
  input  logic [LANES-1:0]           alt_read,
  input  logic [LANES-1:0]           alt_write,
  input  logic [LANES*DW-1:0]        alt_wdata,
  output logic [LANES*DW-1:0]        alt_rdata,
  output logic [LANES-1:0]           alt_waitreq,
  output logic [LANES*(HOST_AW-3)-1:0] rcfg_addr,
  output logic [LANES-1:0]           rcfg_read,
  output logic [LANES-1:0]           rcfg_write,
  output logic [LANES*DW-1:0]        rcfg_wdata,
  input  logic [LANES*DW-1:0]        rcfg_rdata,
  input  logic [LANES-1:0]           rcfg_waitreq,
  input  logic [DW-1:0]              meas_count,
  input  logic                       meas_valid,
  input  logic                       pwrup_cal_done,
  input  logic                       rx_cal_busy,
  output logic [$clog2(LANES+1)-1:0] lane_sel,
  output logic                       rcfg_en,
  output logic                       rx_reset
);
  localparam int RCFG_AW = HOST_AW - 3;
  localparam int LSEL_W  = $clog2(LANES + 1);

  region_e       region;
  logic          in_win, lane_ok, host_live, sel_wait;
  logic [DW-1:0] sel_rdata, local_rdata;

  rxcsr_decode #(.HOST_AW(HOST_AW)) u_decode (
    .addr   (host_addr),
    .region (region)
  );

  assign in_win    = (region == RG_WIN);
  assign lane_ok   = (lane_sel < LSEL_W'(LANES));
  assign host_live = in_win && rcfg_en && lane_ok;

  rxcsr_regs #(.DW(DW), .LSEL_W(LSEL_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .region         (region),
    .wr_en          (host_write && !in_win),
    .wdata          (host_wdata),
    .meas_count     (meas_count),
    .meas_valid     (meas_valid),
    .pwrup_cal_done (pwrup_cal_done),
    .rx_cal_busy    (rx_cal_busy),
    .sel_wait       (sel_wait),
    .lane_q         (lane_sel),
    .own_q          (rcfg_en),
    .rst_q          (rx_reset),
    .rdata          (local_rdata)
  );

  rxcsr_lane_mux #(.LANES(LANES), .AW(RCFG_AW), .DW(DW), .LSEL_W(LSEL_W)) u_mux (
    .own          (rcfg_en),
    .host_live    (host_live),
    .lane_sel     (lane_sel),
    .host_baddr   (host_addr[HOST_AW-2:2]),
    .host_read    (host_read),
    .host_write   (host_write),
    .host_wdata   (host_wdata),
    .alt_addr     (alt_addr),
    .alt_read     (alt_read),
    .alt_write    (alt_write),
    .alt_wdata    (alt_wdata),
    .alt_rdata    (alt_rdata),
    .alt_waitreq  (alt_waitreq),
    .rcfg_addr    (rcfg_addr),
    .rcfg_read    (rcfg_read),
    .rcfg_write   (rcfg_write),
    .rcfg_wdata   (rcfg_wdata),
    .rcfg_rdata   (rcfg_rdata),
    .rcfg_waitreq (rcfg_waitreq),
    .sel_wait     (sel_wait),
    .sel_rdata    (sel_rdata)
  );

  assign host_waitrequest = host_live && (host_read || host_write) && sel_wait;
  assign host_rdata = host_live ? sel_rdata : (in_win ? '0 : local_rdata);
endmodule

// File: rtl/rxphy_csr_bridge_chk.sv
module rxphy_csr_bridge_chk #(
  parameter int LANES   = 3,
  parameter int DW      = 32,
  parameter int HOST_AW = 13
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [HOST_AW-1:0]         host_addr,
  input logic                       host_read,
  input logic                       host_write,
  input logic [DW-1:0]              host_wdata,
  input logic [DW-1:0]              host_rdata,
  input logic                       host_waitrequest,
  input logic [LANES-1:0]           alt_waitreq,
  input logic [LANES-1:0]           rcfg_read,
  input logic [LANES-1:0]           rcfg_write,
  input logic [LANES-1:0]           rcfg_waitreq,
  input logic [DW-1:0]              meas_count,
  input logic [$clog2(LANES+1)-1:0] lane_sel,
  input logic                       rcfg_en,
  input logic                       rx_reset
);
  localparam int LSEL_W = $clog2(LANES + 1);
  logic is_win, is_local, acc, blocked, past_ok, sel_wq;

  assign is_win   = host_addr < HOST_AW'(32'h1000);
  assign is_local = !is_win;
  assign acc      = host_read || host_write;
  assign blocked  = !rcfg_en || (lane_sel >= LSEL_W'(LANES));

  always_comb begin
    sel_wq = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (lane_sel == LSEL_W'(i)) sel_wq = rcfg_waitreq[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_LOCAL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_local && acc) |-> !host_waitrequest); // R12
  AST_ONE_LANE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rcfg_en |-> $onehot0(rcfg_read | rcfg_write)); // R3
  AST_STALL_FOLLOWS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_win && acc && !blocked) |-> (host_waitrequest == sel_wq)); // R4
  AST_BLOCKED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_win && host_read && blocked) |-> (!host_waitrequest && host_rdata == '0)); // R6
  AST_ALT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rcfg_en |-> (&alt_waitreq)); // R5
  AST_MEAS_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && host_read && host_addr == HOST_AW'(32'h1000)) |-> host_rdata == $past(meas_count)); // R9
  AST_RESET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_write && host_addr == HOST_AW'(32'h1060)) |=> rx_reset == $past(host_wdata[0])); // R8
endmodule

bind rxphy_csr_bridge rxphy_csr_bridge_chk #(.LANES(LANES), .DW(DW), .HOST_AW(HOST_AW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .host_addr        (host_addr),
  .host_read        (host_read),
  .host_write       (host_write),
  .host_wdata       (host_wdata),
  .host_rdata       (host_rdata),
  .host_waitrequest (host_waitrequest),
  .alt_waitreq      (alt_waitreq),
  .rcfg_read        (rcfg_read),
  .rcfg_write       (rcfg_write),
  .rcfg_waitreq     (rcfg_waitreq),
  .meas_count       (meas_count),
  .lane_sel         (lane_sel),
  .rcfg_en          (rcfg_en),
  .rx_reset         (rx_reset)
);

// File: tb/rxphy_csr_bridge_bench.sv
`timescale 1ns/1ps
module rxphy_csr_bridge_bench;
  localparam int L = 3, DW = 32, HAW = 13, RAW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HAW-1:0]  ha = '0;
  logic            hr = 1'b0, hw = 1'b0;
  logic [DW-1:0]   hwd = '0;
  logic [DW-1:0]   hrd;
  logic            hwait;
  logic [L*RAW-1:0] a_addr = '0, r_addr;
  logic [L-1:0]     a_rd = '0, a_wr = '0, a_wait, r_rd, r_wr, r_wait = '0;
  logic [L*DW-1:0]  a_wd = '0, a_rdata, r_wd, r_rdata = '0;
  logic [DW-1:0]    meas = '0;
  logic             mval = 1'b0, cdone = 1'b0, cbusy = 1'b0;
  logic [1:0]       lsel;
  logic             own, rxr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxphy_csr_bridge u_rxphy_csr_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(ha), .host_read(hr), .host_write(hw),
    .host_wdata(hwd), .host_rdata(hrd), .host_waitrequest(hwait),
    .alt_addr(a_addr), .alt_read(a_rd), .alt_write(a_wr), .alt_wdata(a_wd),
    .alt_rdata(a_rdata), .alt_waitreq(a_wait),
    .rcfg_addr(r_addr), .rcfg_read(r_rd), .rcfg_write(r_wr), .rcfg_wdata(r_wd),
    .rcfg_rdata(r_rdata), .rcfg_waitreq(r_wait),
    .meas_count(meas), .meas_valid(mval), .pwrup_cal_done(cdone), .rx_cal_busy(cbusy),
    .lane_sel(lsel), .rcfg_en(own), .rx_reset(rxr)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] d);
    @(negedge clk); ha = HAW'(addr); hwd = d; hw = 1'b1;
    @(posedge clk); #1; hw = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [DW-1:0] d);
    @(negedge clk); ha = HAW'(addr); hr = 1'b1; #2;
    d = hrd;
    check("R12 local stall", DW'(hwait), 0);
    hr = 1'b0;
  endtask

  // Expected per-lane strobe vector for a host window access
  function automatic logic [L-1:0] exp_strobe(input bit en, input int ls, input bit s, input logic [L-1:0] alt);
    logic [L-1:0] v = '0;
    if (!en) return alt;
    if (ls < L && s) v[ls] = 1'b1;
    return v;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 lane_sel reset", DW'(lsel), 0);
    check("R1 rcfg_en reset", DW'(own), 0);
    check("R1 rx_reset reset", DW'(rxr), 0);
    rst_n = 1'b1;
    rd(32'h1040, v); check("R1 lane reg", v, 0);
    rd(32'h1050, v); check("R1 own reg", v, 0);
    rd(32'h1060, v); check("R1 rst reg", v, 0);

    // R7 reserved masking, R8 control bits
    wr(32'h1040, 32'hFFFF_FFFE); rd(32'h1040, v); check("R7 lane rw", v, 2);
    check("R7 lane_sel pin", DW'(lsel), 2);
    wr(32'h1050, 32'hFFFF_FFFF); rd(32'h1050, v); check("R8 own rw", v, 1);
    check("R8 rcfg_en pin", DW'(own), 1);
    wr(32'h1060, 32'h3); check("R8 rx_reset pin", DW'(rxr), 1);
    rd(32'h1060, v); check("R8 rst rw", v, 1);
    wr(32'h1060, 32'h0); check("R8 rx_reset clear", DW'(rxr), 0);

    // R11 read-only and unmapped writes ignored
    wr(32'h1044, 32'h1); check("R11 unmapped write lane", DW'(lsel), 2);
    wr(32'h1054, 32'h0); check("R11 unmapped write own", DW'(own), 1);
    wr(32'h1080, 32'hFFFF_FFFF); rd(32'h1080, v); check("R11 cfg reads 0", v, 0);
    meas = 32'hA5A5_1234;
    wr(32'h1000, 32'h0); rd(32'h1000, v); check("R11 RO write ignored", v, 32'hA5A5_1234);
    rd(32'h1004, v); check("R11 0x1004 unmapped", v, 0);
    rd(32'h10F0, v); check("R11 0x10F0 unmapped", v, 0);

    // R4 directed stall then data, lane 2
    r_wait = 3'b100; r_rdata = {32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};
    @(negedge clk); ha = 13'h0124; hr = 1'b1; #2;
    check("R4 stall held", DW'(hwait), 1);
    check("R2 addr xlate", DW'(r_addr[2*RAW +: RAW]), 32'h49);
    @(negedge clk); r_wait = 3'b000; #2;
    check("R4 stall released", DW'(hwait), 0);
    check("R4 rdata lane2", hrd, 32'hC0DE_0002);
    hr = 1'b0;

    // R10 live waitrequest
    r_wait = 3'b100; rd(32'h1070, v); check("R10 live wait", v, 1);
    wr(32'h1040, 32'h3); rd(32'h1070, v); check("R10 lane3 wait", v, 0);
    // R6 lane 3 blocked
    @(negedge clk); ha = 13'h0010; hr = 1'b1; #2;
    check("R6 lane3 no stall", DW'(hwait), 0);
    check("R6 lane3 rdata", hrd, 0);
    check("R6 lane3 strobes", DW'(r_rd), 0);
    hr = 1'b0; r_wait = '0;

    // R9 status sampling
    for (int k = 0; k < 20; k++) begin
      logic [DW-1:0] m = $urandom;
      logic b0 = 1'($urandom), b1 = 1'($urandom), b2 = 1'($urandom);
      @(negedge clk); meas = m; mval = b0; cdone = b1; cbusy = b2;
      rd(32'h1000, v); check("R9 meas", v, m);
      rd(32'h1010, v); check("R9 mvalid", v, DW'(b0));
      rd(32'h1020, v); check("R9 caldone", v, DW'(b1));
      rd(32'h1030, v); check("R9 calbusy", v, DW'(b2));
    end

    // Random window traffic: R2 R3 R4 R5 R6
    for (int k = 0; k < 400; k++) begin
      int ls = int'($urandom % 4);
      bit en = 1'($urandom);
      bit isrd = 1'($urandom);
      int off = int'($urandom % 32'h1000);
      bit live;
      wr(32'h1040, DW'(ls));
      wr(32'h1050, DW'(en));
      @(negedge clk);
      a_addr = {$urandom, $urandom}; a_rd = 3'($urandom); a_wr = 3'($urandom);
      a_wd = {$urandom, $urandom, $urandom}; r_wait = 3'($urandom);
      r_rdata = {$urandom, $urandom, $urandom};
      ha = HAW'(off); hwd = $urandom; hr = isrd; hw = !isrd;
      #2;
      live = en && ls < L;
      check("R3 R5 read strobes", DW'(r_rd), DW'(exp_strobe(en, ls, isrd, a_rd)));
      check("R3 R5 write strobes", DW'(r_wr), DW'(exp_strobe(en, ls, !isrd, a_wr)));
      check("R5 alt wait", DW'(a_wait), en ? 32'h7 : DW'(r_wait));
      for (int i = 0; i < L; i++) begin
        check("R2 R5 lane addr", DW'(r_addr[i*RAW +: RAW]),
              en ? DW'(off >> 2) : DW'(a_addr[i*RAW +: RAW]));
        check("R3 R5 lane wdata", r_wd[i*DW +: DW], en ? hwd : a_wd[i*DW +: DW]);
        check("R5 alt rdata", a_rdata[i*DW +: DW], r_rdata[i*DW +: DW]);
      end
      check("R4 R6 stall", DW'(hwait), live ? DW'(r_wait[ls]) : 0);
      if (isrd) check("R4 R6 rdata", hrd, live ? r_rdata[ls*DW +: DW] : 0);
      hr = 1'b0; hw = 1'b0; r_wait = '0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule